// File: doc/BRIEF.md
# Mode-Selectable Call Stack Controller

This block runs the subroutine stack of a small processor with a 4-bit datapath and a 14-bit program counter. A call request saves the return address into RAM one nibble at a time. A return request reads that address back from RAM. The RAM itself sits outside the block and is reached through a nibble-wide port with a synchronous read. The stack pointer is 8 bits wide and lives inside one of three 256-nibble RAM banks. The full RAM address is the bank number followed by the pointer.

A 4-bit configuration register sits at data address F84H and is written like any other data location. It chooses the bank that holds the stack. It also chooses between two frame formats:
- **Compact:** a call stores four nibbles.
- **Extended:** a call stores six nibbles, adding a byte of padding, and each operation takes one more machine cycle.

Every operation lasts a fixed number of machine cycles. The block raises a one-cycle done pulse in the last of them.

Top module: `callstk_ctrl`

## Requirements
- R1: After reset the configuration register reads 4'b1000 (compact mode, bank 0), the stack pointer is 0, and busy, done, cfg_err and ram_we are low.
- R2: A write with cfg_addr equal to F84H updates the register. Bit 3 = 1 selects compact mode and bit 3 = 0 selects extended mode. Bits 1:0 select bank 0, 1 or 2. A write to any other address leaves the register unchanged.
- R3: A register write with bit 2 set is rejected as a whole. cfg_err pulses for one cycle and the register keeps its value.
- R4: A register write whose bits 1:0 are 2'b11 pulses cfg_err for one cycle and leaves the bank unchanged. Bit 3 still takes the written value.
- R5: req_op 2'b00 is a long call, 2'b01 a short call and 2'b10 a return. Each takes a fixed number of machine cycles: long call 3 (compact) or 4 (extended), short call 2 or 3, return 3 or 4. With MC_CLKS clocks per machine cycle, busy is high for that many clocks starting in the cycle after acceptance, and done is high for exactly the last of them.
- R6: A call in compact mode writes four nibbles. The frame is {2'b00, pc_in}, written most significant nibble first. The pointer is decremented before each write, and each write goes to {bank, pointer}.
- R7: A call in extended mode writes six nibbles. The first two written are zero padding, followed by the same four nibbles as in compact mode.
- R8: A return reads as many nibbles as the mode in force when it is accepted calls for, four or six. It never writes RAM. The pointer is incremented after each read. The restored 14-bit address is on pc_out in the cycle where done is high.
- R9: The stack pointer wraps modulo 256 inside the selected bank, both on writes (from 00 down to FF) and on reads (from FF up to 00).
- R10: A request arriving while busy is high is ignored. It causes no RAM access and does not lengthen or change the running operation.
- R11: A register write that arrives while busy is high is held back. It is applied, and checked for errors, at the clock edge that ends the done cycle. It becomes visible in the following cycle, and a later held write replaces an earlier one.
- R12: req_op 2'b11 is not an operation: it neither sets busy nor touches RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 00 long call, 01 short call, 10 return, 11 none |
| pc_in | input | 14 | Return address to save on a call |
| cfg_we | input | 1 | Data write strobe |
| cfg_addr | input | 12 | Data write address |
| cfg_wdata | input | 4 | Data write value |
| cfg_q | output | 4 | Current configuration register value |
| cfg_err | output | 1 | One-cycle pulse for a rejected or partly rejected register write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse in the last cycle of an operation |
| pc_out | output | 14 | Address restored by a return |
| ram_addr | output | 10 | RAM nibble address: bank then pointer |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 4 | RAM write nibble |
| ram_rdata | input | 4 | RAM read nibble, one cycle after ram_addr |

## Verification
The assertions take for granted that the RAM returns the addressed nibble exactly one clock after the address appears. They also take for granted that MC_CLKS is at least 2, so that every nibble transfer fits inside its operation window. The bench models a synchronous-read RAM with that latency, keeps the default clocks-per-machine-cycle, and presents requests and register writes for one cycle at a time on the falling edge. Requests and writes that arrive during an operation are injected on purpose at chosen points in the busy window, never outside the interface protocol.

// File: rtl/callstk_pkg.sv
package callstk_pkg;
  localparam int REG_W     = 4;
  localparam int MODE_BIT  = 3;
  localparam int RSV_BIT   = 2;
  localparam int BANK_W    = 2;
  localparam int NUM_BANKS = 3;
  localparam int MAX_MC    = 4;

  typedef enum logic [1:0] {
    OP_CALL  = 2'b00,
    OP_CALLF = 2'b01,
    OP_RET   = 2'b10,
    OP_NONE  = 2'b11
  } stk_op_e;

  // machine cycles of an operation, ext = extended frame mode
  function automatic int op_mcycles(stk_op_e op, logic ext);
    case (op)
      OP_CALL:  return ext ? 4 : 3;
      OP_CALLF: return ext ? 3 : 2;
      OP_RET:   return ext ? 4 : 3;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/callstk_cfg.sv
module callstk_cfg
  import callstk_pkg::*;
#(
  parameter int DADDR_W = 12,
  parameter logic [DADDR_W-1:0] CFG_ADDR = 12'hF84
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               busy,
  input  logic               done,
  output logic [REG_W-1:0]   reg_q,
  output logic               err
);
  localparam logic [REG_W-1:0] RESET_VAL = REG_W'(1) << MODE_BIT;

  logic             hit;
  logic             pend_v;
  logic [REG_W-1:0] pend_d;
  logic             app_v;
  logic [REG_W-1:0] app_d;

  assign hit = wr_en && (wr_addr == CFG_ADDR);

  always_comb begin
    app_v = 1'b0;
    app_d = wr_data;
    if (!busy) begin
      app_v = hit;
    end else if (done) begin
      app_v = hit || pend_v;
      app_d = hit ? wr_data : pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q  <= RESET_VAL;
      err    <= 1'b0;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      err <= 1'b0;
      if (app_v) begin
        if (app_d[RSV_BIT]) begin
          err <= 1'b1;
        end else begin
          reg_q[MODE_BIT] <= app_d[MODE_BIT];
          if (int'(app_d[BANK_W-1:0]) >= NUM_BANKS) err <= 1'b1;
          else reg_q[BANK_W-1:0] <= app_d[BANK_W-1:0];
        end
      end
      if (busy && done) begin
        pend_v <= 1'b0;
      end else if (busy && hit) begin
        pend_v <= 1'b1;
        pend_d <= wr_data;
      end
    end
  end

  assert_reset_compact_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_q == RESET_VAL));
  assert_rsv_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !reg_q[RSV_BIT]);
  assert_bank_legal_R4: assert property (@(posedge clk) disable iff (rst)
    int'(reg_q[BANK_W-1:0]) < NUM_BANKS);
  assert_hold_mid_op_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(reg_q));
endmodule

// File: rtl/callstk_seq.sv
module callstk_seq
  import callstk_pkg::*;
#(
  parameter int MC_CLKS = 2,
  parameter int CNT_W   = $clog2(MAX_MC * MC_CLKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             ext_mode,
  output logic             accept,
  output logic             acc_ret,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt,
  output logic             op_ret_q,
  output logic             op_ext_q
);
  stk_op_e          op;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] total_q;

  assign op      = stk_op_e'(req_op);
  assign accept  = req_valid && !busy && (op != OP_NONE);
  assign acc_ret = (op == OP_RET);
  assign total   = CNT_W'(op_mcycles(op, ext_mode) * MC_CLKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      total_q  <= '0;
      op_ret_q <= 1'b0;
      op_ext_q <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      cnt      <= '0;
      total_q  <= total;
      op_ret_q <= acc_ret;
      op_ext_q <= ext_mode;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) begin
        busy <= 1'b0;
        done <= 1'b0;
      end else if (cnt == total_q - CNT_W'(2)) begin
        done <= 1'b1;
      end
    end
  end

  assert_done_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_keeps_op_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && $stable(op_ret_q) && $stable(op_ext_q)));
endmodule

// File: rtl/callstk_dp.sv
module callstk_dp
  import callstk_pkg::*;
#(
  parameter int PC_W  = 14,
  parameter int NIB_W = 4,
  parameter int SP_W  = 8,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic                   acc_ret,
  input  logic                   acc_ext,
  input  logic [BANK_W-1:0]      bank,
  input  logic [PC_W-1:0]        pc_in,
  input  logic                   busy,
  input  logic [CNT_W-1:0]       cnt,
  input  logic                   op_ret_q,
  input  logic                   op_ext_q,
  input  logic [NIB_W-1:0]       ram_rdata,
  output logic [BANK_W+SP_W-1:0] ram_addr,
  output logic                   ram_we,
  output logic [NIB_W-1:0]       ram_wdata,
  output logic [PC_W-1:0]        pc_out
);
  localparam int NIBS_C  = (PC_W + NIB_W - 1) / NIB_W;
  localparam int NIBS_X  = NIBS_C + 8 / NIB_W;
  localparam int FRAME_W = NIBS_X * NIB_W;
  localparam int ACC_W   = NIBS_C * NIB_W;

  logic [SP_W-1:0]    sp_q, sp_dec, sp_inc;
  logic [BANK_W-1:0]  bank_q;
  logic [FRAME_W-1:0] frame_q, frame_new;
  logic [ACC_W-1:0]   pc_acc;
  int                 acc_nibs, run_nibs, step, wr_idx, cap_idx;
  logic               issue, cap;

  assign sp_dec    = sp_q - 1'b1;
  assign sp_inc    = sp_q + 1'b1;
  assign frame_new = FRAME_W'(pc_in);
  assign pc_out    = pc_acc[PC_W-1:0];

  always_comb begin
    acc_nibs = acc_ext ? NIBS_X : NIBS_C;
    run_nibs = op_ext_q ? NIBS_X : NIBS_C;
    step     = int'(cnt) + 1;
    issue    = busy && (step < run_nibs);
    wr_idx   = run_nibs - 1 - step;
    if (wr_idx < 0) wr_idx = 0;
    cap      = busy && op_ret_q && (int'(cnt) >= 1) && (int'(cnt) - 1 < NIBS_C);
    cap_idx  = cap ? int'(cnt) - 1 : 0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= '0;
      bank_q    <= '0;
      frame_q   <= '0;
      pc_acc    <= '0;
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      if (accept) begin
        bank_q  <= bank;
        frame_q <= frame_new;
        if (acc_ret) begin
          ram_addr <= {bank, sp_q};
          sp_q     <= sp_inc;
        end else begin
          ram_addr  <= {bank, sp_dec};
          ram_we    <= 1'b1;
          ram_wdata <= frame_new[(acc_nibs-1)*NIB_W +: NIB_W];
          sp_q      <= sp_dec;
        end
      end else if (issue) begin
        if (op_ret_q) begin
          ram_addr <= {bank_q, sp_q};
          sp_q     <= sp_inc;
        end else begin
          ram_addr  <= {bank_q, sp_dec};
          ram_we    <= 1'b1;
          ram_wdata <= frame_q[wr_idx*NIB_W +: NIB_W];
          sp_q      <= sp_dec;
        end
      end
      if (cap) pc_acc[cap_idx*NIB_W +: NIB_W] <= ram_rdata;
    end
  end

  assert_write_in_op_R6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);
  assert_ret_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && op_ret_q) |-> !ram_we);
  assert_predec_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |->
      (ram_addr[SP_W-1:0] == SP_W'($past(ram_addr[SP_W-1:0]) - 1'b1)));
  assert_bank_field_R2: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (int'(ram_addr[BANK_W+SP_W-1:SP_W]) < NUM_BANKS));
endmodule

// File: rtl/callstk_ctrl.sv
module callstk_ctrl
  import callstk_pkg::*;
#(
  parameter int PC_W    = 14,
  parameter int NIB_W   = 4,
  parameter int SP_W    = 8,
  parameter int DADDR_W = 12,
  parameter logic [DADDR_W-1:0] CFG_ADDR = 12'hF84,
  parameter int MC_CLKS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_op,
  input  logic [PC_W-1:0]        pc_in,
  input  logic                   cfg_we,
  input  logic [DADDR_W-1:0]     cfg_addr,
  input  logic [REG_W-1:0]       cfg_wdata,
  output logic [REG_W-1:0]       cfg_q,
  output logic                   cfg_err,
  output logic                   busy,
  output logic                   done,
  output logic [PC_W-1:0]        pc_out,
  output logic [BANK_W+SP_W-1:0] ram_addr,
  output logic                   ram_we,
  output logic [NIB_W-1:0]       ram_wdata,
  input  logic [NIB_W-1:0]       ram_rdata
);
  localparam int CNT_W = $clog2(MAX_MC * MC_CLKS + 1);

  logic             accept, acc_ret, op_ret_q, op_ext_q, ext_mode;
  logic [CNT_W-1:0] cnt;

  assign ext_mode = !cfg_q[MODE_BIT];

  callstk_cfg #(.DADDR_W(DADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .busy(busy), .done(done),
    .reg_q(cfg_q), .err(cfg_err)
  );

  callstk_seq #(.MC_CLKS(MC_CLKS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .ext_mode(ext_mode), .accept(accept), .acc_ret(acc_ret),
    .busy(busy), .done(done), .cnt(cnt),
    .op_ret_q(op_ret_q), .op_ext_q(op_ext_q)
  );

  callstk_dp #(.PC_W(PC_W), .NIB_W(NIB_W), .SP_W(SP_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .acc_ret(acc_ret),
    .acc_ext(ext_mode), .bank(cfg_q[BANK_W-1:0]), .pc_in(pc_in),
    .busy(busy), .cnt(cnt), .op_ret_q(op_ret_q), .op_ext_q(op_ext_q),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .pc_out(pc_out)
  );
endmodule

// File: tb/callstk_ctrl_bench.sv
module callstk_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b11;
  logic [13:0] pc_in = '0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_q, ram_wdata, ram_rdata;
  logic        cfg_err, busy, done, ram_we;
  logic [13:0] pc_out;
  logic [9:0]  ram_addr;

  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = '0;
  logic [3:0]  pre_data = '0;
  logic [3:0]  mem [0:1023];
  int          wcount = 0;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callstk_ctrl u_callstk_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .pc_in(pc_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .cfg_err(cfg_err),
    .busy(busy), .done(done), .pc_out(pc_out), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    else if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wcount <= wcount + 1;
    end
    ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [3:0] v,
                           output logic e1, output logic e2);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0; e1 = cfg_err;
    @(negedge clk); e2 = cfg_err;
  endtask

  task automatic preload(input logic [9:0] a, input logic [3:0] v);
    @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_data = v;
    @(negedge clk); pre_we = 1'b0;
  endtask

  // inj_kind: 0 none, 1 extra request, 2 register write of inj_val
  task automatic run_op(input logic [1:0] op, input logic [13:0] pc,
                        input int inj_at, input int inj_kind, input logic [3:0] inj_val,
                        output int lat, output int nw, output logic b0,
                        output logic [3:0] q_done, output logic [13:0] pc_done);
    int base;
    @(negedge clk);
    base = wcount;
    req_valid = 1'b1; req_op = op; pc_in = pc;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b11; lat = 1; b0 = busy;
    while (!done && lat < 64) begin
      if (lat == inj_at && inj_kind == 1) begin req_valid = 1'b1; req_op = 2'b00; end
      if (lat == inj_at && inj_kind == 2) begin
        cfg_we = 1'b1; cfg_addr = 12'hF84; cfg_wdata = inj_val;
      end
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'b11; cfg_we = 1'b0;
      lat++;
    end
    q_done = cfg_q; pc_done = pc_out;
    @(negedge clk);
    nw = wcount - base;
  endtask

  int lat, nw;
  logic b0, e1, e2;
  logic [3:0] qd;
  logic [13:0] pd;

  task automatic t_reset();
    do_reset();
    chk("R1", "cfg_q", 32'(cfg_q), 32'h8);
    chk("R1", "busy/done/err/we", {28'd0, busy, done, cfg_err, ram_we}, 32'h0);
  endtask

  task automatic t_compact();
    do_reset();
    run_op(2'b00, 14'h2A5C, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R5", "call compact latency", 32'(lat), 32'(3*MC));
    chk("R5", "busy after accept", 32'(b0), 32'h1);
    chk("R6", "compact writes", 32'(nw), 32'h4);
    chk("R9", "wrap write 0FF", 32'(mem[10'h0FF]), 32'h2);
    chk("R6", "nibbles FE..FC", {20'd0, mem[10'h0FE], mem[10'h0FD], mem[10'h0FC]}, 32'hA5C);
    run_op(2'b10, 14'h0, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R5", "ret compact latency", 32'(lat), 32'(3*MC));
    chk("R8", "ret pc at done", 32'(pd), 32'h2A5C);
    chk("R8", "ret writes", 32'(nw), 32'h0);
    run_op(2'b01, 14'h0001, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R5", "short call compact latency", 32'(lat), 32'(2*MC));
  endtask

  task automatic t_extended();
    do_reset();
    cfg_write(12'hF84, 4'b0001, e1, e2);
    chk("R2", "cfg_q ext bank1", 32'(cfg_q), 32'h1);
    chk("R2", "no err", 32'(e1), 32'h0);
    run_op(2'b01, 14'h3FFF, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R5", "short call ext latency", 32'(lat), 32'(3*MC));
    chk("R7", "ext writes", 32'(nw), 32'h6);
    chk("R7", "ext frame 1FF..1FA",
        {8'd0, mem[10'h1FF], mem[10'h1FE], mem[10'h1FD], mem[10'h1FC], mem[10'h1FB], mem[10'h1FA]},
        32'h003FFF);
    run_op(2'b00, 14'h0123, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R5", "long call ext latency", 32'(lat), 32'(4*MC));
    chk("R7", "ext frame 1F9..1F4",
        {8'd0, mem[10'h1F9], mem[10'h1F8], mem[10'h1F7], mem[10'h1F6], mem[10'h1F5], mem[10'h1F4]},
        32'h000123);
    run_op(2'b10, 14'h0, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R5", "ret ext latency", 32'(lat), 32'(4*MC));
    chk("R8", "ret ext pc", 32'(pd), 32'h0123);
    run_op(2'b10, 14'h0, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R8", "second ret ext pc", 32'(pd), 32'h3FFF);
  endtask

  task automatic t_cfg_errors();
    do_reset();
    cfg_write(12'hF85, 4'b0000, e1, e2);
    chk("R2", "other address ignored", 32'(cfg_q), 32'h8);
    cfg_write(12'hF84, 4'b1100, e1, e2);
    chk("R3", "bit2 err pulse", {30'd0, e1, e2}, 32'h2);
    chk("R3", "bit2 reg kept", 32'(cfg_q), 32'h8);
    cfg_write(12'hF84, 4'b0011, e1, e2);
    chk("R4", "bank3 err pulse", {30'd0, e1, e2}, 32'h2);
    chk("R4", "bank kept mode taken", 32'(cfg_q), 32'h0);
  endtask

  task automatic t_busy_ignore();
    do_reset();
    run_op(2'b00, 14'h1111, 2, 1, 4'h0, lat, nw, b0, qd, pd);
    chk("R10", "latency unchanged", 32'(lat), 32'(3*MC));
    chk("R10", "writes unchanged", 32'(nw), 32'h4);
    chk("R10", "idle after done", 32'(busy), 32'h0);
    @(negedge clk); req_valid = 1'b1; req_op = 2'b11;
    @(negedge clk); req_valid = 1'b0;
    chk("R12", "no-op not busy", 32'(busy), 32'h0);
    run_op(2'b10, 14'h0, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R10", "stack intact pc", 32'(pd), 32'h1111);
  endtask

  task automatic t_defer();
    do_reset();
    run_op(2'b00, 14'h0AAA, 2, 2, 4'b0010, lat, nw, b0, qd, pd);
    chk("R11", "reg at done", 32'(qd), 32'h8);
    chk("R11", "reg after done", 32'(cfg_q), 32'h2);
  endtask

  task automatic t_wrap_read();
    do_reset();
    cfg_write(12'hF84, 4'b0000, e1, e2);
    run_op(2'b00, 14'h1357, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    cfg_write(12'hF84, 4'b1000, e1, e2);
    run_op(2'b10, 14'h0, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R8", "compact ret of ext frame", 32'(pd), 32'h1357);
    chk("R8", "compact ret latency", 32'(lat), 32'(3*MC));
    preload(10'h0FE, 4'h7);
    preload(10'h0FF, 4'h9);
    preload(10'h000, 4'hC);
    preload(10'h001, 4'hE);
    run_op(2'b10, 14'h0, 0, 0, 4'h0, lat, nw, b0, qd, pd);
    chk("R9", "read wrap FF->00", 32'(pd), 32'h2C97);
  endtask

  initial begin
    t_reset();
    t_compact();
    t_extended();
    t_cfg_errors();
    t_busy_ignore();
    t_defer();
    t_wrap_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule